// File: doc/BRIEF.md
# Machine-Cycle Timer / Event Counter

This block is one 16-bit count channel of the kind found beside a small 8-bit processor core. The oscillator clock is divided by twelve to form a machine-cycle strobe, and the channel steps at most once per machine cycle. In timer function it counts machine cycles. In event function it counts high-to-low transitions of an external pin. That pin passes through a two-flop synchronizer and is then sampled once per machine cycle.

Software loads the count one byte at a time through two write strobes that share a data bus. A run input gates counting. A function-select input picks timer or event counting. When the count wraps to zero the block raises an overflow flag. The flag stays set until an interrupt-acknowledge pulse arrives or software writes a new value into it.

Top module: `mcyc_timer`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `count` is 0x0000, `ovf_flag` is 0 and `mc_tick` is 0.
- R2: `mc_tick` is high for exactly one clock in every MC_DIV (default 12) clocks. The first pulse comes MC_DIV clocks after reset is released.
- R3: With `run`=1 and `fn_sel`=0 (timer), `count` increases by one on the clock edge where `mc_tick` is high, and on no other edge.
- R4: With `run`=0 and no byte write, `count` keeps its value whatever `mc_tick`, `ev_pin` or `fn_sel` do.
- R5: With `run`=1 and `fn_sel`=1 (event), a pin sample is taken on every `mc_tick` edge from the second synchronizer flop. `count` increases by one on the following `mc_tick` edge only when the newer sample is 0 and the one before it is 1. A rising transition never counts.
- R6: If the pin level changes no more often than once per machine cycle, each falling transition adds exactly one. A pin that alternates level every machine cycle is counted at one step per two machine cycles.
- R7: A step from 0xFFFF gives 0x0000 and sets `ovf_flag` on the same edge.
- R8: `wr_lo` loads `wr_data` into bits 7:0 and `wr_hi` loads it into bits 15:8. A write in a cycle drops the increment due in that cycle, and the byte that is not written keeps its value.
- R9: An `intack` pulse clears `ovf_flag`. Otherwise, `flag_we` loads `flag_wdata` into `ovf_flag`.
- R10: A wrap sets `ovf_flag` even when `intack` or `flag_we` is asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fn_sel | input | 1 | 0 selects timer function, 1 selects event counting |
| run | input | 1 | Counting enable |
| ev_pin | input | 1 | External event pin, asynchronous |
| wr_lo | input | 1 | Write strobe for the low count byte |
| wr_hi | input | 1 | Write strobe for the high count byte |
| wr_data | input | 8 | Byte write data |
| flag_we | input | 1 | Software write strobe for the overflow flag |
| flag_wdata | input | 1 | Value written to the overflow flag |
| intack | input | 1 | Interrupt-acknowledge pulse, clears the flag |
| count | output | 16 | Current count value |
| ovf_flag | output | 1 | Overflow flag |
| mc_tick | output | 1 | Machine-cycle strobe |

## Verification
Two pairs of actions can fall in the same clock. A byte write can coincide with a due increment, and the hardware overflow set can coincide with a flag clear by acknowledge or by software write. The bench provokes each pair on purpose. It waits at a falling clock edge until `mc_tick` is seen high, then asserts the write or the acknowledge in that same cycle. It then judges the byte that was written, the byte that was not, and whether the flag survived. Random stimulus adds more such collisions at a low rate, and a bench reference model checks all of them.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_MC_DIV = 12;
    localparam int unsigned DEF_SYNC   = 2;

    typedef enum logic {
        FN_TIMER   = 1'b0,
        FN_COUNTER = 1'b1
    } fn_sel_e;

    typedef struct packed {
        logic       lo_we;
        logic       hi_we;
        logic [7:0] data;
    } byte_wr_t;

    typedef struct packed {
        logic we;
        logic wdata;
        logic ack;
    } flag_ctl_t;

    function automatic logic any_write(input byte_wr_t w);
        return w.lo_we | w.hi_we;
    endfunction

endpackage

// File: rtl/mc_strobe_gen.sv
module mc_strobe_gen #(
    parameter int unsigned MC_DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned DW = (MC_DIV > 1) ? $clog2(MC_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(MC_DIV - 1);

    logic [DW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                 phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/pin_fall_sampler.sv
module pin_fall_sampler #(
    parameter int unsigned SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic [SYNC-1:0] sync_q;
    logic            older_q;
    logic            newer_q;

    generate
        if (SYNC == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= pin;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC-2:0], pin};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= 1'b0;
            newer_q <= 1'b0;
        end else if (tick) begin
            older_q <= newer_q;
            newer_q <= sync_q[SYNC-1];
        end
    end

    assign fall = older_q & ~newer_q;
endmodule

// File: rtl/count_core.sv
module count_core
    import mcyc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  byte_wr_t         bwr,
    input  flag_ctl_t        fctl,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    localparam int unsigned BW = CNT_W / 2;

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;
    logic             wrote;
    logic             wrap;

    assign wrote = any_write(bwr);
    assign wrap  = step & ~wrote & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wrote) begin
            if (bwr.lo_we) cnt_q[BW-1:0]     <= bwr.data[BW-1:0];
            if (bwr.hi_we) cnt_q[CNT_W-1:BW] <= bwr.data[BW-1:0];
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (fctl.ack) flag_q <= 1'b0;
        else if (fctl.we) flag_q <= fctl.wdata;
    end

    assign cnt  = cnt_q;
    assign flag = flag_q;
endmodule

// File: rtl/mcyc_timer.sv
module mcyc_timer
    import mcyc_pkg::*;
#(
    parameter int unsigned CNT_W  = DEF_CNT_W,
    parameter int unsigned MC_DIV = DEF_MC_DIV,
    parameter int unsigned SYNC   = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fn_sel,
    input  logic             run,
    input  logic             ev_pin,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    input  logic             flag_we,
    input  logic             flag_wdata,
    input  logic             intack,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             mc_tick
);
    fn_sel_e   mode;
    byte_wr_t  bwr;
    flag_ctl_t fctl;
    logic      tick;
    logic      fall;
    logic      step;

    assign mode = fn_sel_e'(fn_sel);
    assign bwr  = '{lo_we: wr_lo, hi_we: wr_hi, data: wr_data};
    assign fctl = '{we: flag_we, wdata: flag_wdata, ack: intack};

    mc_strobe_gen #(.MC_DIV(MC_DIV)) u_strobe (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pin_fall_sampler #(.SYNC(SYNC)) u_sampler (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .pin  (ev_pin),
        .fall (fall)
    );

    always_comb begin
        step = 1'b0;
        if (run && tick) begin
            case (mode)
                FN_TIMER:   step = 1'b1;
                FN_COUNTER: step = fall;
                default:    step = 1'b0;
            endcase
        end
    end

    count_core #(.CNT_W(CNT_W)) u_core (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .bwr  (bwr),
        .fctl (fctl),
        .cnt  (count),
        .flag (ovf_flag)
    );

    assign mc_tick = tick;
endmodule

// File: rtl/mcyc_timer_chk.sv
module mcyc_timer_chk #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned MC_DIV = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             fn_sel,
    input logic             run,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic [7:0]       wr_data,
    input logic             intack,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag,
    input logic             mc_tick
);
    localparam int unsigned GW = $clog2(MC_DIV) + 1;

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (mc_tick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R2
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (seen_q && mc_tick) |-> (gap_q == GW'(MC_DIV - 1)));

    // R3
    a_r3_timer_step: assert property (@(posedge clk) disable iff (rst)
        (run && mc_tick && !fn_sel && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1));

    // R3, R5: no change between strobes without a write
    a_r3_quiet_off_tick: assert property (@(posedge clk) disable iff (rst)
        (!mc_tick && !wr_lo && !wr_hi) |=> $stable(count));

    // R4
    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_lo && !wr_hi) |=> $stable(count));

    // R7, R10
    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (run && mc_tick && !fn_sel && !wr_lo && !wr_hi && (&count)) |=> (count == '0 && ovf_flag));

    // R8
    a_r8_low_write: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (count[7:0] == $past(wr_data) && count[CNT_W-1:8] == $past(count[CNT_W-1:8])));

    // R9
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (intack && !mc_tick) |=> !ovf_flag);
endmodule

bind mcyc_timer mcyc_timer_chk #(.CNT_W(CNT_W), .MC_DIV(MC_DIV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fn_sel   (fn_sel),
    .run      (run),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wr_data  (wr_data),
    .intack   (intack),
    .count    (count),
    .ovf_flag (ovf_flag),
    .mc_tick  (mc_tick)
);

// File: tb/mcyc_timer_test.sv
`timescale 1ns/1ps
module mcyc_timer_test;
    localparam int MC_DIV = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fn_sel = 1'b0, run = 1'b0, ev_pin = 1'b0;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        flag_we = 1'b0, flag_wdata = 1'b0, intack = 1'b0;
    logic [15:0] count;
    logic        ovf_flag, mc_tick;

    int checks = 0;
    int failures = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcyc_timer uut (
        .clk(clk), .rst(rst), .fn_sel(fn_sel), .run(run), .ev_pin(ev_pin),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .flag_we(flag_we), .flag_wdata(flag_wdata), .intack(intack),
        .count(count), .ovf_flag(ovf_flag), .mc_tick(mc_tick)
    );

    // Reference model built from the requirements
    int          m_phase;
    logic        m_s1, m_s2, m_old, m_new, m_flag;
    logic [15:0] m_cnt;

    function automatic logic ref_tick(input int ph);
        return ph == MC_DIV - 1;
    endfunction

    function automatic logic ref_step(input logic t, input logic r, input logic f,
                                      input logic o, input logic n);
        if (!(t && r)) return 1'b0;
        return f ? (o && !n) : 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase <= 0; m_s1 <= 0; m_s2 <= 0; m_old <= 0; m_new <= 0;
            m_cnt <= 16'h0; m_flag <= 0;
        end else begin
            logic st, wr, wrap;
            m_phase <= ref_tick(m_phase) ? 0 : m_phase + 1;
            m_s1 <= ev_pin; m_s2 <= m_s1;
            if (ref_tick(m_phase)) begin m_old <= m_new; m_new <= m_s2; end
            st   = ref_step(ref_tick(m_phase), run, fn_sel, m_old, m_new);
            wr   = wr_lo || wr_hi;
            wrap = st && !wr && (m_cnt == 16'hFFFF);
            if (wr) begin
                if (wr_lo) m_cnt[7:0]  <= wr_data;
                if (wr_hi) m_cnt[15:8] <= wr_data;
            end else if (st) m_cnt <= m_cnt + 16'h1;
            if (wrap)         m_flag <= 1'b1;
            else if (intack)  m_flag <= 1'b0;
            else if (flag_we) m_flag <= flag_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en && !rst) begin
            chk("R2 model tick",                 {31'b0, mc_tick},  {31'b0, ref_tick(m_phase)});
            chk("R3 R4 R5 R6 R8 model count",    {16'b0, count},    {16'b0, m_cnt});
            chk("R7 R9 R10 model flag",          {31'b0, ovf_flag}, {31'b0, m_flag});
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!mc_tick);
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk); wr_lo = 1; wr_data = v[7:0];
        @(negedge clk); wr_lo = 0; wr_hi = 1; wr_data = v[15:8];
        @(negedge clk); wr_hi = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] c0;
        void'($urandom(32'd1234));
        cyc(4);
        chk("R1 count in reset", {16'b0, count}, 32'h0);
        chk("R1 flag in reset",  {31'b0, ovf_flag}, 32'h0);
        rst = 0;
        @(negedge clk);
        chk("R1 count after reset", {16'b0, count}, 32'h0);
        chk("R1 tick after reset",  {31'b0, mc_tick}, 32'h0);
        mon_en = 1;

        // R2: spacing between strobes
        begin
            int gap = 0;
            wait_tick();
            do begin @(negedge clk); gap++; end while (!mc_tick);
            chk("R2 tick spacing", gap, MC_DIV);
        end

        // R3: timer counts one per machine cycle
        load(16'h0010);
        fn_sel = 0; run = 1; c0 = count;
        cyc(5 * MC_DIV);
        chk("R3 five machine cycles", {16'b0, count}, {16'b0, c0 + 16'd5});

        // R4: stopped holds, even with pin activity and mode change
        run = 0; c0 = count;
        for (int i = 0; i < 5 * MC_DIV; i++) begin
            ev_pin = i[3]; fn_sel = i[4];
            @(negedge clk);
        end
        fn_sel = 0; ev_pin = 0;
        chk("R4 held while stopped", {16'b0, count}, {16'b0, c0});

        // R7: wrap sets flag
        load(16'hFFFF);
        run = 1;
        cyc(MC_DIV);
        run = 0;
        chk("R7 wrapped to zero", {16'b0, count}, 32'h0);
        chk("R7 flag set on wrap", {31'b0, ovf_flag}, 32'h1);

        // R9: acknowledge and software write
        @(negedge clk); intack = 1; @(negedge clk); intack = 0;
        chk("R9 ack clears flag", {31'b0, ovf_flag}, 32'h0);
        flag_we = 1; flag_wdata = 1; @(negedge clk); flag_we = 0;
        chk("R9 software sets flag", {31'b0, ovf_flag}, 32'h1);
        flag_we = 1; flag_wdata = 0; @(negedge clk); flag_we = 0;
        chk("R9 software clears flag", {31'b0, ovf_flag}, 32'h0);

        // R10: wrap in the same cycle as ack and clearing write
        load(16'hFFFF);
        wait_tick();
        run = 1; intack = 1; flag_we = 1; flag_wdata = 0;
        @(negedge clk);
        run = 0; intack = 0; flag_we = 0;
        chk("R10 wrap count", {16'b0, count}, 32'h0);
        chk("R10 flag survives ack", {31'b0, ovf_flag}, 32'h1);
        intack = 1; @(negedge clk); intack = 0;

        // R8: low-byte write collides with an increment
        load(16'h1234);
        wait_tick();
        run = 1; wr_lo = 1; wr_data = 8'h55;
        @(negedge clk);
        run = 0; wr_lo = 0;
        chk("R8 write beats increment", {16'b0, count}, 32'h1255);

        // R5, R6: event counting at the highest rate
        ev_pin = 1; cyc(3 * MC_DIV);
        load(16'h0000);
        fn_sel = 1; run = 1;
        cyc(3 * MC_DIV);
        chk("R5 rising edge does not count", {16'b0, count}, 32'h0);
        for (int k = 0; k < 10; k++) begin
            ev_pin = 0; cyc(MC_DIV);
            ev_pin = 1; cyc(MC_DIV);
        end
        cyc(4 * MC_DIV);
        chk("R6 ten edges at max rate", {16'b0, count}, 32'd10);
        run = 0;

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] r = $urandom;
            if (r[5:0] == 0)   run = ~run;
            if (r[13:6] == 0)  fn_sel = ~fn_sel;
            if (r[16:14] == 0) ev_pin = ~ev_pin;
            wr_lo = (r[22:17] == 0);
            wr_hi = (r[28:23] == 0);
            wr_data = r[29] ? 8'hFF : 8'(r[31:24]);
            intack = ($urandom_range(0, 31) == 0);
            flag_we = ($urandom_range(0, 63) == 0);
            flag_wdata = r[30];
            @(negedge clk);
        end
        wr_lo = 0; wr_hi = 0; intack = 0; flag_we = 0;
        cyc(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule